// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches one 16-bit word from a three-wire (Microwire-style) serial configuration EEPROM. A host pulses a request with a word address and a width choice of 6 or 8 address bits. The block then enables the serial port, selects the device and clocks out a command word. The command is a leading start bit, the two read opcode bits and the address. The block then clocks in sixteen data bits, releases the device, and returns the word together with a one-cycle completion pulse.

Some devices need 8 address bits and others need 6, and a board does not always know which kind it carries. For that case an automatic mode first reads word 0 with 8 address bits. If that word matches a fixed signature (0x8129 by default), the device is treated as the 8-bit kind. Otherwise it is treated as the 6-bit kind. The requested word is then read with the chosen width, and the chosen width is reported. Every level of the serial clock is held for a parameterised number of system clocks, so slow devices can be served from a fast system clock.

Top module: `ee3w_reader`

## Requirements
- R1: While reset is held and directly after it, port enable, chip select, serial clock, data-in, done and busy are all low.
- R2: The command is shifted MSB first and is the start bit 1, then opcode bits 1 and 0, then the address. That gives 11 bits in 8-bit mode (all of the address) and 9 bits in 6-bit mode (the low 6 address bits only; the upper two are ignored).
- R3: Port enable rises while chip select is low, and stays high for at least one half-period before chip select rises.
- R4: Data-in changes only while the serial clock is low. It is held stable for the whole of every high clock phase.
- R5: After the command, the clock goes low for one half-period. Sixteen data bits are then taken MSB first, each sampled at the end of a high clock phase, and the result appears on the read data output.
- R6: Serial clock pulses happen only with chip select high. One access has exactly command-length plus 16 rising clock edges. Chip select falls after the 16th data bit, with the clock low.
- R7: Every level of the serial clock lasts at least HALF_CYC system clocks.
- R8: In automatic mode, word 0 is first read with 8 address bits. A value equal to the signature selects 8-bit mode and any other value selects 6-bit mode. The requested word is then read in that mode, and the mode used is shown on the width output (1 means 8 bits).
- R9: A request that arrives while busy is ignored: it causes no device access and no extra done pulse, and it does not change the returned word.
- R10: Done is a single-cycle pulse raised when the result is valid. Busy is high from the cycle after a request until done.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_i | input | 1 | Read request pulse, taken only when idle |
| rd_addr_i | input | 8 | Word address (low 6 bits used in 6-bit mode) |
| wide_i | input | 1 | 1 selects 8 address bits, 0 selects 6 |
| auto_i | input | 1 | 1 selects width automatically from word 0 |
| rd_data_o | output | 16 | Word read from the device |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Access in progress |
| wide_o | output | 1 | Address width used by the last access |
| ee_en_o | output | 1 | Serial port program enable |
| ee_cs_o | output | 1 | Device chip select |
| ee_sk_o | output | 1 | Serial clock to the device |
| ee_di_o | output | 1 | Serial data to the device |
| ee_do_i | input | 1 | Serial data from the device |

## Verification
The assertions assume that reset is applied before any request and that the device data line only changes in response to serial clock edges, well before the block samples it. The bench device model meets this by updating its output only on a rising serial clock, which is HALF_CYC system clocks before the sample point. The probe read on a 6-bit device returns a shifted word, and the model produces that word the same way a real part would, so it can never equal the signature by accident.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;
  localparam logic [2:0] READ_CMD = 3'b110;   // start bit + read opcode

  typedef enum logic [3:0] {
    X_IDLE, X_ENA, X_CSON, X_CLO, X_CHI, X_GAP, X_RHI, X_RLO, X_END
  } xfer_st_t;

  typedef enum logic [2:0] {
    T_IDLE, T_PGO, T_PWAIT, T_MGO, T_MWAIT
  } ctl_st_t;
endpackage

// File: rtl/ee3w_tick.sv
module ee3w_tick #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == LAST);
    cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ee3w_xfer.sv
module ee3w_xfer
  import ee3w_pkg::*;
#(
  parameter int ADDR_WIDE   = 8,
  parameter int ADDR_NARROW = 6,
  parameter int DATA_W      = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 start,
  input  logic                 wide,
  input  logic [ADDR_WIDE-1:0] addr,
  output logic                 run,
  output logic                 fin,
  output logic [DATA_W-1:0]    rdata,
  output logic                 en_o,
  output logic                 cs_o,
  output logic                 sk_o,
  output logic                 di_o,
  input  logic                 do_i
);
  localparam int CMD_W  = 3 + ADDR_WIDE;
  localparam int CMD_N  = 3 + ADDR_NARROW;
  localparam int MAXB   = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int CNT_W  = $clog2(MAXB);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(CMD_N - 1);
  localparam logic [CNT_W-1:0] LAST_DATA   = CNT_W'(DATA_W - 1);

  xfer_st_t           st_q, st_d;
  logic [CMD_W-1:0]   sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d, last_q, last_d;
  logic [DATA_W-1:0]  rd_q, rd_d;

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    rd_d   = rd_q;
    fin    = 1'b0;
    unique case (st_q)
      X_IDLE: if (start) begin
        st_d  = X_ENA;
        cnt_d = '0;
        if (wide) begin
          sh_d   = {READ_CMD, addr};
          last_d = LAST_WIDE;
        end else begin
          sh_d   = {READ_CMD, addr[ADDR_NARROW-1:0], {(ADDR_WIDE-ADDR_NARROW){1'b0}}};
          last_d = LAST_NARROW;
        end
      end
      X_ENA:  if (tick) st_d = X_CSON;
      X_CSON: if (tick) st_d = X_CLO;
      X_CLO:  if (tick) st_d = X_CHI;
      X_CHI:  if (tick) begin
        if (cnt_q == last_q) begin
          cnt_d = '0;
          st_d  = X_GAP;
        end else begin
          cnt_d = cnt_q + 1'b1;
          sh_d  = {sh_q[CMD_W-2:0], 1'b0};
          st_d  = X_CLO;
        end
      end
      X_GAP:  if (tick) st_d = X_RHI;
      X_RHI:  if (tick) begin
        rd_d = {rd_q[DATA_W-2:0], do_i};
        st_d = X_RLO;
      end
      X_RLO:  if (tick) begin
        if (cnt_q == LAST_DATA) st_d = X_END;
        else begin
          cnt_d = cnt_q + 1'b1;
          st_d  = X_RHI;
        end
      end
      X_END:  if (tick) begin
        fin  = 1'b1;
        st_d = X_IDLE;
      end
      default: st_d = X_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= X_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      last_q <= '0;
      rd_q   <= '0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
      rd_q   <= rd_d;
    end
  end

  // Moore decode of the pins from the state register
  always_comb begin
    run   = (st_q != X_IDLE);
    en_o  = (st_q != X_IDLE) && (st_q != X_END);
    cs_o  = (st_q == X_CSON) || (st_q == X_CLO) || (st_q == X_CHI) ||
            (st_q == X_GAP)  || (st_q == X_RHI) || (st_q == X_RLO);
    sk_o  = (st_q == X_CHI) || (st_q == X_RHI);
    di_o  = ((st_q == X_CLO) || (st_q == X_CHI)) && sh_q[CMD_W-1];
    rdata = rd_q;
  end
endmodule

// File: rtl/ee3w_reader.sv
module ee3w_reader
  import ee3w_pkg::*;
#(
  parameter int          HALF_CYC    = 4,
  parameter int          ADDR_WIDE   = 8,
  parameter int          ADDR_NARROW = 6,
  parameter int          DATA_W      = 16,
  parameter logic [15:0] WIDE_SIG    = 16'h8129
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_req_i,
  input  logic [ADDR_WIDE-1:0] rd_addr_i,
  input  logic                 wide_i,
  input  logic                 auto_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 done_o,
  output logic                 busy_o,
  output logic                 wide_o,
  output logic                 ee_en_o,
  output logic                 ee_cs_o,
  output logic                 ee_sk_o,
  output logic                 ee_di_o,
  input  logic                 ee_do_i
);
  ctl_st_t                st_q, st_d;
  logic [ADDR_WIDE-1:0]   addr_q, addr_d;
  logic                   wide_q, wide_d;
  logic [DATA_W-1:0]      data_q, data_d;
  logic                   done_q, done_d;

  logic                   x_run, x_tick, x_start, x_fin, x_wide;
  logic [ADDR_WIDE-1:0]   x_addr;
  logic [DATA_W-1:0]      x_rdata;

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    wide_d  = wide_q;
    data_d  = data_q;
    done_d  = 1'b0;
    x_start = 1'b0;
    x_addr  = addr_q;
    x_wide  = wide_q;
    unique case (st_q)
      T_IDLE: if (rd_req_i) begin
        addr_d = rd_addr_i;
        wide_d = wide_i;
        st_d   = auto_i ? T_PGO : T_MGO;
      end
      T_PGO: begin
        x_start = 1'b1;
        x_addr  = '0;
        x_wide  = 1'b1;
        st_d    = T_PWAIT;
      end
      T_PWAIT: begin
        x_addr = '0;
        x_wide = 1'b1;
        if (x_fin) begin
          wide_d = (x_rdata[15:0] == WIDE_SIG);
          st_d   = T_MGO;
        end
      end
      T_MGO: begin
        x_start = 1'b1;
        st_d    = T_MWAIT;
      end
      T_MWAIT: if (x_fin) begin
        data_d = x_rdata;
        done_d = 1'b1;
        st_d   = T_IDLE;
      end
      default: st_d = T_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= T_IDLE;
      addr_q <= '0;
      wide_q <= 1'b0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      wide_q <= wide_d;
      data_q <= data_d;
      done_q <= done_d;
    end
  end

  ee3w_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(x_run), .tick(x_tick)
  );

  ee3w_xfer #(
    .ADDR_WIDE(ADDR_WIDE), .ADDR_NARROW(ADDR_NARROW), .DATA_W(DATA_W)
  ) u_xfer (
    .clk(clk), .rst_n(rst_n), .tick(x_tick), .start(x_start),
    .wide(x_wide), .addr(x_addr), .run(x_run), .fin(x_fin),
    .rdata(x_rdata), .en_o(ee_en_o), .cs_o(ee_cs_o), .sk_o(ee_sk_o),
    .di_o(ee_di_o), .do_i(ee_do_i)
  );

  assign rd_data_o = data_q;
  assign done_o    = done_q;
  assign busy_o    = (st_q != T_IDLE);
  assign wide_o    = wide_q;
endmodule

// File: rtl/ee3w_reader_chk.sv
module ee3w_reader_chk #(
  parameter int HALF_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic cs,
  input logic sk,
  input logic di,
  input logic done,
  input logic busy
);
  logic        sk_prev;
  logic [15:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_prev <= 1'b0;
      hold    <= 16'hFFFF;
    end else begin
      sk_prev <= sk;
      if (sk != sk_prev)      hold <= 16'd1;
      else if (hold != 16'hFFFF) hold <= hold + 16'd1;
    end
  end

  assert_en_before_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs) |-> (en && $past(en)));

  assert_di_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sk && $past(sk)) |-> $stable(di));

  assert_clk_inside_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sk |-> cs);

  assert_cs_drop_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs) |-> (!sk && !$past(sk)));

  assert_half_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sk != sk_prev) |-> (hold >= 16'(HALF_CYC)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
endmodule

bind ee3w_reader ee3w_reader_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ee_en_o), .cs(ee_cs_o), .sk(ee_sk_o),
  .di(ee_di_o), .done(done_o), .busy(busy_o)
);

// File: tb/ee3w_reader_tb.sv
module ee3w_reader_tb;
  localparam int HALF = 4;

  logic        clk, rst_n;
  logic        rd_req, wide_in, auto_in;
  logic [7:0]  rd_addr;
  logic [15:0] rd_data;
  logic        done, busy, wide_out;
  logic        ee_en, ee_cs, ee_sk, ee_di, ee_do;

  int checks = 0, errors = 0, cycles = 0, n_done = 0;

  ee3w_reader #(.HALF_CYC(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .wide_i(wide_in), .auto_i(auto_in), .rd_data_o(rd_data), .done_o(done),
    .busy_o(busy), .wide_o(wide_out), .ee_en_o(ee_en), .ee_cs_o(ee_cs),
    .ee_sk_o(ee_sk), .ee_di_o(ee_di), .ee_do_i(ee_do)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  // ---------------- device model ----------------
  logic        m_wide = 1'b1;
  logic [15:0] m_w0   = 16'h8129;
  int          m_cnt = 0, m_acc = 0, m_last_edges = 0;
  logic [10:0] m_cmd = '0, m_last_cmd = '0;

  function automatic logic [15:0] wf(input logic [7:0] a);
    if (a == 8'h00) return m_w0;
    return {a ^ 8'h5a, ~a};
  endfunction

  always @(posedge ee_cs) begin m_cnt = 0; m_cmd = '0; end
  always @(negedge ee_cs) begin
    m_acc++; m_last_cmd = m_cmd; m_last_edges = m_cnt;
  end
  always @(posedge ee_sk) if (ee_cs) begin
    if (m_cnt < (m_wide ? 11 : 9)) m_cmd = {m_cmd[9:0], ee_di};
    m_cnt++;
  end

  always_comb begin
    int nb, k;
    logic [7:0] a;
    nb = m_wide ? 11 : 9;
    a  = m_wide ? m_cmd[7:0] : {2'b00, m_cmd[5:0]};
    ee_do = 1'b0;
    if (ee_cs && m_cnt > nb && m_cnt <= nb + 16) begin
      k = 15 - (m_cnt - nb - 1);
      ee_do = wf(a)[k];
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (done) n_done++;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] a, input logic w, input logic au,
                         output logic [15:0] d);
    int lim = 0;
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a; wide_in = w; auto_in = au;
    @(negedge clk);
    rd_req = 1'b0;
    while (!done && lim < 5000) begin @(negedge clk); lim++; end
    chk(done, "R10", "done seen", done, 1);
    d = rd_data;
    @(negedge clk);
    chk(!done && !busy, "R10", "done single pulse, busy low", {done, busy}, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0; rd_req = 1'b0; rd_addr = '0; wide_in = 1'b0; auto_in = 1'b0;
    repeat (3) @(negedge clk);
    chk({ee_en, ee_cs, ee_sk, ee_di, done, busy} == 6'b0, "R1", "pins in reset",
        {ee_en, ee_cs, ee_sk, ee_di, done, busy}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({ee_en, ee_cs, ee_sk, ee_di, done, busy} == 6'b0, "R1", "pins after reset",
        {ee_en, ee_cs, ee_sk, ee_di, done, busy}, 0);
  endtask

  task automatic t_wide(input logic [7:0] a);
    logic [15:0] d; int acc0;
    m_wide = 1'b1; acc0 = m_acc;
    do_read(a, 1'b1, 1'b0, d);
    chk(m_last_cmd == {3'b110, a}, "R2", "wide command", m_last_cmd, {3'b110, a});
    chk(m_last_edges == 27, "R6", "wide edge count", m_last_edges, 27);
    chk(d == wf(a), "R5", "wide data", d, wf(a));
    chk(m_acc == acc0 + 1, "R6", "one access", m_acc - acc0, 1);
  endtask

  task automatic t_narrow(input logic [7:0] a);
    logic [15:0] d; logic [7:0] lo;
    m_wide = 1'b0; lo = {2'b00, a[5:0]};
    do_read(a, 1'b0, 1'b0, d);
    chk(m_last_cmd == {2'b00, 3'b110, a[5:0]}, "R2", "narrow command",
        m_last_cmd, {2'b00, 3'b110, a[5:0]});
    chk(m_last_edges == 25, "R6", "narrow edge count", m_last_edges, 25);
    chk(d == wf(lo), "R5", "narrow data (upper addr bits ignored)", d, wf(lo));
  endtask

  task automatic t_auto_wide();
    logic [15:0] d; int acc0;
    m_wide = 1'b1; m_w0 = 16'h8129; acc0 = m_acc;
    do_read(8'hC3, 1'b0, 1'b1, d);
    chk(m_acc == acc0 + 2, "R8", "probe plus main access", m_acc - acc0, 2);
    chk(wide_out == 1'b1, "R8", "signature picks 8-bit", wide_out, 1);
    chk(m_last_cmd == {3'b110, 8'hC3}, "R8", "main command 8-bit",
        m_last_cmd, {3'b110, 8'hC3});
    chk(d == wf(8'hC3), "R8", "auto wide data", d, wf(8'hC3));
  endtask

  task automatic t_auto_narrow();
    logic [15:0] d;
    m_wide = 1'b0; m_w0 = 16'h1234;
    do_read(8'h15, 1'b1, 1'b1, d);
    chk(wide_out == 1'b0, "R8", "no signature picks 6-bit", wide_out, 0);
    chk(m_last_cmd == {2'b00, 3'b110, 6'h15}, "R8", "main command 6-bit",
        m_last_cmd, {2'b00, 3'b110, 6'h15});
    chk(d == wf(8'h15), "R8", "auto narrow data", d, wf(8'h15));
    m_w0 = 16'h8129;
  endtask

  task automatic t_busy_ignore();
    logic [15:0] d; int acc0, dn0, lim;
    m_wide = 1'b1; acc0 = m_acc; dn0 = n_done; lim = 0;
    @(negedge clk);
    rd_req = 1'b1; rd_addr = 8'h3C; wide_in = 1'b1; auto_in = 1'b0;
    @(negedge clk); rd_req = 1'b0;
    repeat (20) @(negedge clk);
    rd_req = 1'b1; rd_addr = 8'h99; auto_in = 1'b1;
    @(negedge clk); rd_req = 1'b0; auto_in = 1'b0;
    while (!done && lim < 5000) begin @(negedge clk); lim++; end
    d = rd_data;
    repeat (600) @(negedge clk);
    chk(d == wf(8'h3C), "R9", "first request data kept", d, wf(8'h3C));
    chk(m_acc == acc0 + 1, "R9", "no extra access", m_acc - acc0, 1);
    chk(n_done == dn0 + 1, "R9", "single done", n_done - dn0, 1);
    chk(!busy, "R9", "idle afterwards", busy, 0);
  endtask

  initial begin
    t_reset();
    t_wide(8'hA7);
    t_wide(8'h01);
    t_narrow(8'h2D);
    t_narrow(8'hED);
    t_auto_wide();
    t_auto_narrow();
    t_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule